// File: doc/BRIEF.md
# Counted-Assertion Interrupt Router with Remote IRR

The router serves 32 interrupt pins. A pin has no sampled input wire. Sources send assert, deassert and pulse requests instead, and each pin keeps a signed count of the requests it has received. Each pin also has a routing entry, written in 32-bit halves, that sets its vector, delivery mode, destination mode, trigger mode and mask. The upper half supplies the destination.

An edge on a pin's count from zero to one raises a delivery attempt. A write to a level-triggered entry whose count is positive also raises one. So does an end-of-interrupt broadcast that retires the pin's remote IRR while the count is still positive. Pending attempts are kept in a bitmap.

The engine is a two-state machine. In SCAN it takes the lowest pending pin and judges it with the pin's current entry. A masked pin is dropped. A level pin whose remote IRR is already set is suppressed. Any other pin is latched as a message, remote IRR is set for level pins, and the machine moves to OFFER. The transition SCAN→SCAN covers an empty bitmap and a dropped or suppressed attempt. SCAN→OFFER loads a message. OFFER→OFFER is a stall while the receiver holds ready low. OFFER→SCAN happens when the message is accepted.

Top module: `irq_route_engine`

## Requirements
- R1: req_op encodes 0 = assert (+1), 1 = deassert (−1) and 2 = pulse (net zero). Code 3 does nothing. The count is signed 8-bit and saturates at +127 and −128.
- R2: A delivery attempt is raised only when an assert or pulse finds the count at zero. No other count change raises one.
- R3: An attempt on a pin with mask (entry bit 16) set is discarded. Clearing the mask later on an edge pin does not revive it.
- R4: On a level pin (bit 15 = 1), an attempt is suppressed while remote IRR is set. Otherwise the message sets remote IRR. Edge pins (bit 15 = 0) never set it.
- R5: An end-of-interrupt with vector V clears remote IRR on every pin whose IRR is set and whose entry bits 7:0 equal V. Each of those pins with a count above zero then re-attempts.
- R6: Any write to a pin's entry re-attempts if the resulting entry is level-triggered and the count is above zero.
- R7: Message fields come from the entry. The vector is bits 7:0, the delivery mode bits 10:8, the destination mode bit 11 and the level flag bit 15. The destination is bits 31:24 of the upper half (the upper word shifted right by 24).
- R8: A write that leaves the pin edge-triggered clears its remote IRR. Bit 14 of written data is ignored, because remote IRR is read-only.
- R9: A request or entry write naming pin 32 or higher has no effect and raises err_range for exactly the following cycle.
- R10: Once any count goes negative, err_neg rises and stays high until reset.
- R11: Pending attempts are served in ascending pin order. Only one message is outstanding at a time, and it is held unchanged until msg_ready.
- R12: After reset every entry is masked, all counts and IRRs are zero, and msg_valid, err_range and err_neg are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Pin request strobe |
| req_pin | input | 6 | Requested pin number |
| req_op | input | 2 | Request kind (assert/deassert/pulse) |
| cfg_we | input | 1 | Entry write strobe |
| cfg_pin | input | 6 | Pin whose entry is written |
| cfg_hi | input | 1 | 1 selects the upper half, 0 the lower |
| cfg_data | input | 32 | Write data |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vec | input | 8 | Vector being retired |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination |
| msg_dmode | output | 1 | Destination mode |
| msg_dlv | output | 3 | Delivery mode |
| msg_level | output | 1 | Level-triggered flag |
| err_range | output | 1 | Out-of-range pin seen last cycle |
| err_neg | output | 1 | Sticky negative-count flag |

## Verification
An end-of-interrupt that retires one pin can arrive in the same cycle as a fresh zero-to-one assert on another pin. Both then become pending together. The bench provokes this with a single stimulus cycle that drives eoi_valid and req_valid at once, while msg_ready is held low. The lower pin's re-fired message must appear first and stay unchanged through the stall. The higher pin's edge message must follow once ready rises, and the scoreboard rejects any other order.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int VEC_W  = 8;
    localparam int DLV_W  = 3;
    localparam int DEST_W = 8;

    // bit positions inside the lower entry word
    localparam int B_VEC   = 0;
    localparam int B_DLV   = 8;
    localparam int B_DMODE = 11;
    localparam int B_TRIG  = 15;
    localparam int B_MASK  = 16;
    // destination byte position inside the upper entry word
    localparam int B_DEST  = 24;

    typedef enum logic [1:0] {
        OP_ASSERT   = 2'd0,
        OP_DEASSERT = 2'd1,
        OP_PULSE    = 2'd2,
        OP_NONE     = 2'd3
    } req_op_e;

    typedef enum logic {
        ST_SCAN  = 1'b0,
        ST_OFFER = 1'b1
    } eng_state_e;

    typedef struct packed {
        logic              mask;
        logic              trig;
        logic              dmode;
        logic [DLV_W-1:0]  dlv;
        logic [VEC_W-1:0]  vec;
    } entry_t;

    typedef struct packed {
        logic [VEC_W-1:0]  vec;
        logic [DEST_W-1:0] dest;
        logic              dmode;
        logic [DLV_W-1:0]  dlv;
        logic              lvl;
    } msg_t;

endpackage

// File: rtl/irq_pin_counter.sv
module irq_pin_counter
    import irq_route_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  req_op_e          op_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             rise_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d  = cnt_q;
        rise_o = 1'b0;
        if (hit_i) begin
            unique case (op_i)
                OP_ASSERT: begin
                    rise_o = (cnt_q == '0);
                    cnt_d  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + ONE;
                end
                OP_DEASSERT: begin
                    cnt_d  = (cnt_q == CNT_MIN) ? cnt_q : cnt_q - ONE;
                end
                OP_PULSE: begin
                    rise_o = (cnt_q == '0);
                end
                default: begin
                    cnt_d  = cnt_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int N = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req_i[k]) idx_o = IW'(k);
        end
    end
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
    import irq_route_pkg::*;
#(
    parameter int NPIN  = 32,
    parameter int PIN_W = 6,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PIN_W-1:0]  req_pin,
    input  logic [1:0]        req_op,
    input  logic              cfg_we,
    input  logic [PIN_W-1:0]  cfg_pin,
    input  logic              cfg_hi,
    input  logic [31:0]       cfg_data,
    input  logic              eoi_valid,
    input  logic [VEC_W-1:0]  eoi_vec,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [VEC_W-1:0]  msg_vector,
    output logic [DEST_W-1:0] msg_dest,
    output logic              msg_dmode,
    output logic [DLV_W-1:0]  msg_dlv,
    output logic              msg_level,
    output logic              err_range,
    output logic              err_neg
);
    localparam int               IDX_W   = $clog2(NPIN);
    localparam logic [PIN_W-1:0] PIN_LIM = PIN_W'(NPIN);
    localparam entry_t           ENT_RST = '{mask: 1'b1, trig: 1'b0, dmode: 1'b0,
                                             dlv: '0, vec: '0};

    // request / write decode
    logic             req_ok, cfg_ok;
    logic [IDX_W-1:0] req_idx, cfg_idx;
    req_op_e          op_e;
    entry_t           cfg_ent;
    logic             unused_cfg_bits;

    assign req_ok  = req_valid && (req_pin < PIN_LIM);
    assign cfg_ok  = cfg_we && (cfg_pin < PIN_LIM);
    assign req_idx = req_pin[IDX_W-1:0];
    assign cfg_idx = cfg_pin[IDX_W-1:0];
    assign op_e    = req_op_e'(req_op);
    assign cfg_ent = '{mask:  cfg_data[B_MASK],
                       trig:  cfg_data[B_TRIG],
                       dmode: cfg_data[B_DMODE],
                       dlv:   cfg_data[B_DLV +: DLV_W],
                       vec:   cfg_data[B_VEC +: VEC_W]};
    assign unused_cfg_bits = ^{cfg_data[B_DEST-1:B_MASK+1], cfg_data[B_TRIG-1:B_DMODE+1]};

    // per-pin state
    entry_t            ent  [NPIN];
    logic [DEST_W-1:0] dst  [NPIN];
    logic [CNT_W-1:0]  cnt  [NPIN];
    logic [NPIN-1:0]   pend, pend_nxt;
    logic [NPIN-1:0]   irr, irr_nxt;
    logic [NPIN-1:0]   rise, live, neg, eoi_hit, wr_hit, lvl_after;
    logic [NPIN-1:0]   take, irr_set;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic hit;
        assign hit = req_ok && (req_idx == IDX_W'(i));

        irq_pin_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit_i  (hit),
            .op_i   (op_e),
            .cnt_o  (cnt[i]),
            .rise_o (rise[i])
        );

        assign neg[i]       = cnt[i][CNT_W-1];
        assign live[i]      = !cnt[i][CNT_W-1] && (cnt[i] != '0);
        assign wr_hit[i]    = cfg_ok && (cfg_idx == IDX_W'(i));
        assign lvl_after[i] = wr_hit[i] ? (cfg_hi ? ent[i].trig : cfg_ent.trig)
                                        : ent[i].trig;
        assign eoi_hit[i]   = eoi_valid && irr[i] && (ent[i].vec == eoi_vec);
        assign pend_nxt[i]  = (pend[i] & ~take[i]) | rise[i]
                            | (wr_hit[i] & lvl_after[i] & live[i])
                            | (eoi_hit[i] & live[i]);
        assign irr_nxt[i]   = irr_set[i]
                            | (irr[i] & ~eoi_hit[i] & ~(wr_hit[i] & ~lvl_after[i]));
    end

    // routing table storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NPIN; k++) begin
                ent[k] <= ENT_RST;
                dst[k] <= '0;
            end
        end else if (cfg_ok) begin
            if (cfg_hi) dst[cfg_idx] <= cfg_data[B_DEST +: DEST_W];
            else        ent[cfg_idx] <= cfg_ent;
        end
    end

    // scanner
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    entry_t           sel_ent;
    logic             sel_go;

    irq_lowest_pick #(.N(NPIN)) u_pick (
        .req_i (pend),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    assign sel_ent = ent[pick_idx];
    assign sel_go  = !sel_ent.mask && !(sel_ent.trig && irr[pick_idx]);

    eng_state_e st, st_nxt;
    logic       load;
    msg_t       msg_q;

    always_comb begin
        st_nxt  = st;
        take    = '0;
        irr_set = '0;
        load    = 1'b0;
        unique case (st)
            ST_SCAN: begin
                if (pick_any) begin
                    take[pick_idx] = 1'b1;
                    if (sel_go) begin
                        load              = 1'b1;
                        irr_set[pick_idx] = sel_ent.trig;
                        st_nxt            = ST_OFFER;
                    end
                end
            end
            ST_OFFER: begin
                if (msg_ready) st_nxt = ST_SCAN;
            end
            default: st_nxt = ST_SCAN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_SCAN;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= '0;
            irr       <= '0;
            msg_q     <= '0;
            err_range <= 1'b0;
            err_neg   <= 1'b0;
        end else begin
            pend      <= pend_nxt;
            irr       <= irr_nxt;
            err_range <= (req_valid && !(req_pin < PIN_LIM))
                       || (cfg_we && !(cfg_pin < PIN_LIM));
            err_neg   <= err_neg | (|neg);
            if (load) begin
                msg_q <= '{vec: sel_ent.vec, dest: dst[pick_idx], dmode: sel_ent.dmode,
                           dlv: sel_ent.dlv, lvl: sel_ent.trig};
            end
        end
    end

    // outputs
    always_comb begin
        msg_valid  = (st == ST_OFFER);
        msg_vector = msg_q.vec;
        msg_dest   = msg_q.dest;
        msg_dmode  = msg_q.dmode;
        msg_dlv    = msg_q.dlv;
        msg_level  = msg_q.lvl;
    end

endmodule

// File: rtl/irq_route_engine_chk.sv
module irq_route_engine_chk #(
    parameter int NPIN  = 32,
    parameter int PIN_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [PIN_W-1:0] req_pin,
    input logic             cfg_we,
    input logic [PIN_W-1:0] cfg_pin,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [7:0]       msg_vector,
    input logic [7:0]       msg_dest,
    input logic             msg_dmode,
    input logic [2:0]       msg_dlv,
    input logic             msg_level,
    input logic             err_range,
    input logic             err_neg
);
    localparam logic [PIN_W-1:0] LIM = PIN_W'(NPIN);

    logic bad_pin;
    assign bad_pin = (req_valid && !(req_pin < LIM)) || (cfg_we && !(cfg_pin < LIM));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest)
                                       && $stable(msg_dmode) && $stable(msg_dlv)
                                       && $stable(msg_level)));

    assert_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);

    assert_range_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_pin |=> err_range);

    assert_range_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_pin |=> !err_range);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_neg |=> err_neg);

endmodule

bind irq_route_engine irq_route_engine_chk #(.NPIN(NPIN), .PIN_W(PIN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_pin    (req_pin),
    .cfg_we     (cfg_we),
    .cfg_pin    (cfg_pin),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_vector (msg_vector),
    .msg_dest   (msg_dest),
    .msg_dmode  (msg_dmode),
    .msg_dlv    (msg_dlv),
    .msg_level  (msg_level),
    .err_range  (err_range),
    .err_neg    (err_neg)
);

// File: tb/irq_route_engine_bench.sv
module irq_route_engine_bench;
    localparam int PIN_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [PIN_W-1:0] req_pin = '0;
    logic [1:0]       req_op = '0;
    logic             cfg_we = 1'b0;
    logic [PIN_W-1:0] cfg_pin = '0;
    logic             cfg_hi = 1'b0;
    logic [31:0]      cfg_data = '0;
    logic             eoi_valid = 1'b0;
    logic [7:0]       eoi_vec = '0;
    logic             msg_valid;
    logic             msg_ready = 1'b1;
    logic [7:0]       msg_vector, msg_dest;
    logic             msg_dmode, msg_level;
    logic [2:0]       msg_dlv;
    logic             err_range, err_neg;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [20:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    irq_route_engine u_irq_route_engine (
        .clk, .rst_n, .req_valid, .req_pin, .req_op, .cfg_we, .cfg_pin, .cfg_hi,
        .cfg_data, .eoi_valid, .eoi_vec, .msg_valid, .msg_ready, .msg_vector,
        .msg_dest, .msg_dmode, .msg_dlv, .msg_level, .err_range, .err_neg
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic settle(int n);
        repeat (n) step();
    endtask

    task automatic rq(int pin, logic [1:0] op);
        req_valid = 1'b1; req_pin = PIN_W'(pin); req_op = op;
        step();
        req_valid = 1'b0;
    endtask

    task automatic wr(int pin, bit hi, logic [31:0] d);
        cfg_we = 1'b1; cfg_pin = PIN_W'(pin); cfg_hi = hi; cfg_data = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic eoi(logic [7:0] v);
        eoi_valid = 1'b1; eoi_vec = v;
        step();
        eoi_valid = 1'b0;
    endtask

    task automatic want(logic [7:0] v, logic [7:0] d, bit dm, logic [2:0] dl, bit lv, string tag);
        exp_q.push_back({v, d, dm, dl, lv});
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            logic [20:0] act;
            act = {msg_vector, msg_dest, msg_dmode, msg_dlv, msg_level};
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2/R3/R4 unexpected message", 32'(act), 32'h0);
            end else begin
                logic [20:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(act == e, t, 32'(act), 32'(e));
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(msg_valid == 1'b0, "R12 msg_valid after reset", 32'(msg_valid), 0);
        chk(err_range == 1'b0, "R12 err_range after reset", 32'(err_range), 0);
        chk(err_neg == 1'b0, "R12 err_neg after reset", 32'(err_neg), 0);
        step();
        // reset entries are masked: no message
        rq(0, 2'd0); settle(4); rq(0, 2'd1); settle(2);

        // R7 / R2 / R1 on an edge pin
        wr(3, 1'b1, 32'hA500_0000);
        wr(3, 1'b0, 32'h0000_0941);
        want(8'h41, 8'hA5, 1'b1, 3'd1, 1'b0, "R7 fields edge pin 3");
        rq(3, 2'd0); settle(4);
        rq(3, 2'd0); settle(4);          // 1->2: nothing (R2)
        rq(3, 2'd1); rq(3, 2'd1); settle(2);
        want(8'h41, 8'hA5, 1'b1, 3'd1, 1'b0, "R2 pulse at zero");
        rq(3, 2'd2); settle(4);
        rq(3, 2'd3); settle(3);          // no-op code (R1)
        want(8'h41, 8'hA5, 1'b1, 3'd1, 1'b0, "R1 pulse left count at zero");
        rq(3, 2'd0); settle(4);
        rq(3, 2'd1); settle(2);

        // R3 masked attempt is discarded
        wr(4, 1'b0, 32'h0001_0050);
        rq(4, 2'd0); settle(4);
        wr(4, 1'b0, 32'h0000_0050); settle(4);
        rq(4, 2'd1); settle(2);

        // R4 / R5 level pin
        wr(5, 1'b0, 32'h0000_8060);
        want(8'h60, 8'h00, 1'b0, 3'd0, 1'b1, "R4 level first delivery");
        rq(5, 2'd0); settle(4);
        rq(5, 2'd1); rq(5, 2'd0); settle(4);   // IRR set: suppressed
        eoi(8'h61); settle(4);                  // wrong vector
        want(8'h60, 8'h00, 1'b0, 3'd0, 1'b1, "R5 eoi refire");
        eoi(8'h60); settle(4);
        want(8'h60, 8'h00, 1'b0, 3'd0, 1'b1, "R5 second eoi refire");
        eoi(8'h60); settle(4);
        rq(5, 2'd1); eoi(8'h60); settle(4);     // count zero: no refire

        // R6 / R8 table writes
        wr(6, 1'b0, 32'h0001_8070);
        rq(6, 2'd0); settle(4);                 // masked: dropped
        want(8'h70, 8'h00, 1'b0, 3'd0, 1'b1, "R6 write refire");
        wr(6, 1'b0, 32'h0000_8070); settle(4);
        wr(6, 1'b0, 32'h0000_8070); settle(4);  // IRR set: suppressed (R8 bit14 not cleared by write)
        wr(6, 1'b0, 32'h0000_4070); settle(2);  // edge: clears IRR, bit14 ignored
        want(8'h70, 8'h00, 1'b0, 3'd0, 1'b1, "R8 edge write cleared IRR");
        wr(6, 1'b0, 32'h0000_8070); settle(4);
        rq(6, 2'd1); eoi(8'h70); settle(2);

        // same-cycle EOI and fresh assert, with a stall (R11)
        wr(2, 1'b0, 32'h0000_8022);
        wr(9, 1'b0, 32'h0000_0090);
        want(8'h22, 8'h00, 1'b0, 3'd0, 1'b1, "R4 pin 2 first");
        rq(2, 2'd0); settle(4);
        msg_ready = 1'b0;
        want(8'h22, 8'h00, 1'b0, 3'd0, 1'b1, "R11 lower pin first");
        want(8'h90, 8'h00, 1'b0, 3'd0, 1'b0, "R11 higher pin second");
        eoi_valid = 1'b1; eoi_vec = 8'h22;
        req_valid = 1'b1; req_pin = 6'd9; req_op = 2'd0;
        step();
        eoi_valid = 1'b0; req_valid = 1'b0;
        step();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(msg_valid && msg_vector == 8'h22, "R11 held during stall",
                {23'h0, msg_valid, msg_vector}, 32'h122);
            step();
        end
        msg_ready = 1'b1;
        settle(6);
        rq(2, 2'd1); rq(9, 2'd1); eoi(8'h22); settle(2);

        // ascending order of EOI refires (R11 / R5)
        wr(13, 1'b1, 32'h1300_0000);
        wr(11, 1'b1, 32'h1100_0000);
        wr(13, 1'b0, 32'h0000_8033);
        wr(11, 1'b0, 32'h0000_8033);
        want(8'h33, 8'h13, 1'b0, 3'd0, 1'b1, "R4 pin 13 first delivery");
        rq(13, 2'd0); settle(4);
        want(8'h33, 8'h11, 1'b0, 3'd0, 1'b1, "R4 pin 11 first delivery");
        rq(11, 2'd0); settle(4);
        want(8'h33, 8'h11, 1'b0, 3'd0, 1'b1, "R11 eoi order pin 11");
        want(8'h33, 8'h13, 1'b0, 3'd0, 1'b1, "R11 eoi order pin 13");
        eoi(8'h33); settle(6);

        // R9 out-of-range pins
        rq(40, 2'd0);
        @(negedge clk);
        chk(err_range == 1'b1, "R9 err_range after bad request", 32'(err_range), 1);
        step();
        @(negedge clk);
        chk(err_range == 1'b0, "R9 err_range one cycle only", 32'(err_range), 0);
        step();
        wr(33, 1'b0, 32'h0000_0011);
        @(negedge clk);
        chk(err_range == 1'b1, "R9 err_range after bad write", 32'(err_range), 1);
        step(); settle(3);

        // R10 negative count
        wr(20, 1'b0, 32'h0000_00A0);
        @(negedge clk);
        chk(err_neg == 1'b0, "R10 err_neg still low", 32'(err_neg), 0);
        step();
        rq(20, 2'd1); settle(2);
        @(negedge clk);
        chk(err_neg == 1'b1, "R10 err_neg raised", 32'(err_neg), 1);
        step();
        rq(20, 2'd0); settle(3);                // -1 -> 0: no message
        want(8'hA0, 8'h00, 1'b0, 3'd0, 1'b0, "R2 0->1 after negative");
        rq(20, 2'd0); settle(4);
        @(negedge clk);
        chk(err_neg == 1'b1, "R10 err_neg sticky", 32'(err_neg), 1);
        step();

        // R1 saturation at +127
        for (int k = 0; k < 130; k++) rq(21, 2'd0);
        for (int k = 0; k < 127; k++) rq(21, 2'd1);
        wr(21, 1'b0, 32'h0000_00B1); settle(3);
        want(8'hB1, 8'h00, 1'b0, 3'd0, 1'b0, "R1 saturated count returned to zero");
        rq(21, 2'd0); settle(6);

        chk(exp_q.size() == 0, "R11 all expected messages seen", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule